// File: doc/BRIEF.md
# Polled and Interrupt-Capable Byte Peripheral Port

This block connects a processor-side synchronous register bus to a small set of slow byte-wide peripherals. Each peripheral gets its own window of three registers: a data register, a status register and a command register. The processor writes a command that names one of four operation classes. The block then carries out a single-byte transfer with the chosen peripheral over a valid/ready handshake. While the operation is in flight it reports BUSY, and once a byte is held for the processor it reports READY.

Bytes arriving from a peripheral carry an even-parity bit. A mismatch latches a sticky error flag, which only a control command clears. Each peripheral channel runs in one of two modes. In polled mode the processor watches the status register, and the block never interrupts. In interrupt mode the block raises its interrupt line when a fetched byte is waiting. Reading the data register takes the byte, clears READY and drops the interrupt.

Top module: `pio_port_hub`

## Requirements
- R1: The block responds only when address bits [4:3] equal 2'b01 and address bits [1:0] are 0 (data), 1 (status) or 2 (command). Any other address reads back 8'h00 and is ignored on write.
- R2: Address bit 2 selects peripheral 0 or 1, and each peripheral's registers and state are fully independent of the other's.
- R3: Command bits [1:0] = 2 (fetch) behave as follows. BUSY (status bit 0) sets and the receive-ready output goes high. When the peripheral's valid is seen, the byte is stored, BUSY clears and READY (status bit 1) sets, all in the same cycle.
- R4: Command bits [1:0] = 3 (send) present the last byte written to the data register, with valid held and the byte stable, until the peripheral accepts it. BUSY clears on that acceptance, and READY is not set.
- R5: Incoming words are 9 bits, with the data in [7:0] and the parity bit in [8], and must have an even count of ones. A mismatch sets ERR (status bit 2), which stays set across later good bytes; the byte is still stored.
- R6: Command bits [1:0] = 0 (control) act on wdata bits as follows. Bit 2 clears ERR. Bit 3 gives a one-cycle start pulse to the peripheral. Bit 4 writes the interrupt-mode enable, which is status bit 4.
- R7: Command bits [1:0] = 1 (test) copy the peripheral's power-good input into status bit 3, which holds until the next test.
- R8: While BUSY, fetch, send and test commands, and data register writes, are ignored.
- R9: With interrupt mode off, the interrupt output stays low even when READY is set. With it on, the interrupt is high while READY is set.
- R10: A processor read of the data register returns the stored byte, and from the next cycle READY and the interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Bus select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during a read |
| irq | output | 1 | Interrupt request |
| dev_rx_ready | output | 2 | Per peripheral: block wants a byte |
| dev_rx_valid | input | 2 | Per peripheral: byte offered |
| dev_rx_word | input | 18 | Per peripheral 9-bit word, parity in bit 8 |
| dev_tx_valid | output | 2 | Per peripheral: byte offered to device |
| dev_tx_ready | input | 2 | Per peripheral: device accepts byte |
| dev_tx_data | output | 16 | Per peripheral outgoing byte |
| dev_start | output | 2 | Per peripheral one-cycle start pulse |
| dev_power | input | 2 | Per peripheral power-good level |

## Verification
The hardest situation to create is a command arriving while an operation is still pending. The peripheral model simply withholds its valid or ready, which keeps the channel BUSY. The bench then fires send, test and data writes at it and confirms at the device pins and in status that none of them took effect. A second hard case is the sticky error surviving a later clean byte. To reach it, the bench injects a word with its parity bit flipped and then a correct word before issuing the clearing control command.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;

  typedef enum logic [1:0] {
    CMD_CTRL  = 2'd0,
    CMD_TEST  = 2'd1,
    CMD_FETCH = 2'd2,
    CMD_SEND  = 2'd3
  } cmd_class_e;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CMD  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RX   = 2'd1,
    OP_TX   = 2'd2
  } op_e;

  localparam int ST_BUSY  = 0;
  localparam int ST_READY = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_PWR   = 3;
  localparam int ST_IRQEN = 4;

  localparam int CT_CLR_ERR = 2;
  localparam int CT_START   = 3;
  localparam int CT_IRQ_EN  = 4;

  // even parity: the whole 9-bit word must hold an even number of ones
  function automatic logic parity_ok(input logic [WORD_W-1:0] w);
    return (^w) == 1'b0;
  endfunction
endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NUM_DEV = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h08,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  dev_sel,
  output reg_sel_e          reg_sel
);
  localparam int HI_LSB = 2 + IDX_W;

  logic base_match;
  assign base_match = (addr[ADDR_W-1:HI_LSB] == BASE_ADDR[ADDR_W-1:HI_LSB]);
  assign dev_sel    = addr[HI_LSB-1:2];
  assign reg_sel    = reg_sel_e'(addr[1:0]);
  assign hit        = base_match && (reg_sel != REG_NONE);
endmodule

// File: rtl/pio_dev_channel.sv
module pio_dev_channel
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  reg_sel_e          reg_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              tx_ready,
  input  logic              power,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              start_pulse,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              irq_req
);
  op_e        op;
  cmd_class_e cmd;
  logic busy, ready, err, pwr, irq_en;
  logic [BYTE_W-1:0] tx_buf;

  // named internal events
  logic wr_data, wr_cmd, rd_data;
  logic go_fetch, go_send, go_test, go_ctrl;
  logic rx_fire, tx_fire, parity_bad;

  assign cmd        = cmd_class_e'(wdata[1:0]);
  assign busy       = (op != OP_IDLE);
  assign wr_data    = sel && wr && (reg_sel == REG_DATA);
  assign wr_cmd     = sel && wr && (reg_sel == REG_CMD);
  assign rd_data    = sel && rd && (reg_sel == REG_DATA);
  assign go_fetch   = wr_cmd && (cmd == CMD_FETCH) && !busy;
  assign go_send    = wr_cmd && (cmd == CMD_SEND)  && !busy;
  assign go_test    = wr_cmd && (cmd == CMD_TEST)  && !busy;
  assign go_ctrl    = wr_cmd && (cmd == CMD_CTRL);
  assign rx_fire    = (op == OP_RX) && rx_valid;
  assign tx_fire    = (op == OP_TX) && tx_ready;
  assign parity_bad = rx_fire && !parity_ok(rx_word);

  assign rx_ready = (op == OP_RX);
  assign tx_valid = (op == OP_TX);
  assign tx_data  = tx_buf;
  assign irq_req  = ready && irq_en;

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = busy;
    status[ST_READY]  = ready;
    status[ST_ERR]    = err;
    status[ST_PWR]    = pwr;
    status[ST_IRQEN]  = irq_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op          <= OP_IDLE;
      ready       <= 1'b0;
      err         <= 1'b0;
      pwr         <= 1'b0;
      irq_en      <= 1'b0;
      tx_buf      <= '0;
      rx_byte     <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= go_ctrl && wdata[CT_START];
      if (go_ctrl) irq_en <= wdata[CT_IRQ_EN];
      if (go_test) pwr <= power;
      if (wr_data && !busy) tx_buf <= wdata;

      unique case (op)
        OP_IDLE: if (go_fetch) op <= OP_RX;
                 else if (go_send) op <= OP_TX;
        OP_RX:   if (rx_fire) op <= OP_IDLE;
        OP_TX:   if (tx_fire) op <= OP_IDLE;
        default: op <= OP_IDLE;
      endcase

      if (rx_fire) begin
        rx_byte <= rx_word[BYTE_W-1:0];
        ready   <= 1'b1;
      end else if (go_fetch || rd_data) begin
        ready   <= 1'b0;
      end

      if (parity_bad) err <= 1'b1;
      else if (go_ctrl && wdata[CT_CLR_ERR]) err <= 1'b0;
    end
  end

  // R3: READY only appears after a completed receive handshake
  a_r3_ready_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(rx_fire));

  // R8: a pending operation ends only through its handshake
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_fire && !tx_fire) |=> busy);

  // R5: ERR is sticky until a clearing control command
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(go_ctrl && wdata[CT_CLR_ERR])) |=> err);

  // R10: taking the byte drops READY
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_fire) |=> !ready);

  // R4: outgoing byte is held steady until accepted
  a_r4_tx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/pio_port_hub.sv
module pio_port_hub
  import pio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NUM_DEV = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 5'h08
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_cs,
  input  logic                      bus_rd,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  output logic                      irq,
  output logic [NUM_DEV-1:0]        dev_rx_ready,
  input  logic [NUM_DEV-1:0]        dev_rx_valid,
  input  logic [NUM_DEV*WORD_W-1:0] dev_rx_word,
  output logic [NUM_DEV-1:0]        dev_tx_valid,
  input  logic [NUM_DEV-1:0]        dev_tx_ready,
  output logic [NUM_DEV*BYTE_W-1:0] dev_tx_data,
  output logic [NUM_DEV-1:0]        dev_start,
  input  logic [NUM_DEV-1:0]        dev_power
);
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic             hit;
  logic [IDX_W-1:0] dev_sel;
  reg_sel_e         reg_sel;
  logic [BYTE_W-1:0] ch_status [NUM_DEV];
  logic [BYTE_W-1:0] ch_rx     [NUM_DEV];
  logic [NUM_DEV-1:0] irq_vec;

  pio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .dev_sel(dev_sel), .reg_sel(reg_sel)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_ch
    logic ch_sel;
    assign ch_sel = bus_cs && hit && (dev_sel == IDX_W'(d));
    pio_dev_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (ch_sel),
      .wr         (bus_wr),
      .rd         (bus_rd),
      .reg_sel    (reg_sel),
      .wdata      (bus_wdata),
      .rx_valid   (dev_rx_valid[d]),
      .rx_word    (dev_rx_word[d*WORD_W +: WORD_W]),
      .tx_ready   (dev_tx_ready[d]),
      .power      (dev_power[d]),
      .rx_ready   (dev_rx_ready[d]),
      .tx_valid   (dev_tx_valid[d]),
      .tx_data    (dev_tx_data[d*BYTE_W +: BYTE_W]),
      .start_pulse(dev_start[d]),
      .status     (ch_status[d]),
      .rx_byte    (ch_rx[d]),
      .irq_req    (irq_vec[d])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_cs && bus_rd && hit) begin
      unique case (reg_sel)
        REG_DATA: bus_rdata = ch_rx[dev_sel];
        REG_STAT: bus_rdata = ch_status[dev_sel];
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign irq = |irq_vec;

  // R1: a read outside the decoded window returns zero
  a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_rd && !hit) |-> (bus_rdata == '0));
endmodule

// File: tb/pio_port_hub_tb.sv
module pio_port_hub_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq;
  logic [1:0] dev_rx_ready, dev_rx_valid = '0, dev_tx_valid, dev_tx_ready = '0;
  logic [1:0] dev_start, dev_power = '0;
  logic [17:0] dev_rx_word = '0;
  logic [15:0] dev_tx_data;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pio_port_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dev_rx_ready(dev_rx_ready), .dev_rx_valid(dev_rx_valid), .dev_rx_word(dev_rx_word),
    .dev_tx_valid(dev_tx_valid), .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data),
    .dev_start(dev_start), .dev_power(dev_power)
  );

  // register map per bench: base 0x08, device in bit 2
  function automatic logic [4:0] ra(input int d, input int off);
    return 5'(8 + 4 * d + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #2;
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    #2 v = bus_rdata;
    @(posedge clk); #2;
    bus_cs = 0; bus_rd = 0;
  endtask

  // peripheral model offers a byte, optionally with the parity bit flipped
  task automatic dev_give(input int d, input logic [7:0] b, input bit corrupt);
    logic par;
    par = ($countones(b) % 2 == 1) ^ corrupt;
    @(negedge clk);
    while (!dev_rx_ready[d]) @(negedge clk);
    dev_rx_word[d*9 +: 9] = {par, b};
    dev_rx_valid[d] = 1;
    @(posedge clk); #2;
    dev_rx_valid[d] = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    bus_read(ra(0, 1), v);
    check("R3 reset status", v, 8'h00);
    check("R9 reset irq", irq, 1'b0);
    check("R3 reset rx_ready", dev_rx_ready, 2'b00);
  endtask

  task automatic t_fetch_poll();
    logic [7:0] v;
    bus_write(ra(0, 2), 8'h02);
    check("R3 rx_ready raised", dev_rx_ready[0], 1'b1);
    bus_read(ra(0, 1), v);
    check("R3 busy after fetch", v, 8'h01);
    dev_give(0, 8'hA5, 0);
    bus_read(ra(0, 1), v);
    check("R3 ready after byte", v, 8'h02);
    check("R9 polled mode no irq", irq, 1'b0);
    bus_read(ra(0, 0), v);
    check("R10 data value", v, 8'hA5);
    bus_read(ra(0, 1), v);
    check("R10 ready cleared", v, 8'h00);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    bus_write(ra(0, 2), 8'h02);
    dev_give(0, 8'h3C, 1);
    bus_read(ra(0, 1), v);
    check("R5 err on bad parity", v, 8'h06);
    bus_read(ra(0, 0), v);
    check("R5 bad byte stored", v, 8'h3C);
    bus_write(ra(0, 2), 8'h02);
    dev_give(0, 8'h71, 0);
    bus_read(ra(0, 1), v);
    check("R5 err sticky past good byte", v, 8'h06);
    bus_read(ra(0, 0), v);
    bus_write(ra(0, 2), 8'h04);
    bus_read(ra(0, 1), v);
    check("R6 err cleared", v, 8'h00);
  endtask

  task automatic t_start();
    bus_write(ra(0, 2), 8'h08);
    check("R6 start pulse high", dev_start, 2'b01);
    @(posedge clk); #2;
    check("R6 start pulse one cycle", dev_start, 2'b00);
  endtask

  task automatic t_test_cmd();
    logic [7:0] v;
    dev_power = 2'b01;
    bus_write(ra(0, 2), 8'h01);
    dev_power = 2'b00;
    bus_read(ra(0, 1), v);
    check("R7 power latched", v, 8'h08);
    bus_write(ra(0, 2), 8'h01);
    bus_read(ra(0, 1), v);
    check("R7 power relatched low", v, 8'h00);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    bus_write(5'h0B, 8'h02);
    bus_write(5'h02, 8'h02);
    bus_write(5'h1A, 8'h03);
    check("R1 miss writes ignored pins", {dev_rx_ready, dev_tx_valid}, 4'b0000);
    bus_read(ra(0, 1), v);
    check("R1 miss writes ignored status", v, 8'h00);
    bus_read(5'h00, v);
    check("R1 wrong base reads zero", v, 8'h00);
    bus_read(5'h0B, v);
    check("R1 offset 3 reads zero", v, 8'h00);
  endtask

  task automatic t_busy_and_send();
    logic [7:0] v;
    bus_write(ra(1, 0), 8'h5A);
    bus_write(ra(1, 2), 8'h02);
    bus_write(ra(1, 2), 8'h03);
    bus_write(ra(1, 0), 8'hEE);
    dev_power = 2'b10;
    bus_write(ra(1, 2), 8'h01);
    dev_power = 2'b00;
    check("R8 send ignored while busy", dev_tx_valid, 2'b00);
    bus_read(ra(1, 1), v);
    check("R8 test ignored while busy", v, 8'h01);
    bus_read(ra(0, 1), v);
    check("R2 dev0 untouched", v, 8'h00);
    dev_give(1, 8'h77, 0);
    bus_read(ra(1, 0), v);
    check("R2 dev1 data", v, 8'h77);
    bus_write(ra(1, 2), 8'h03);
    check("R4 tx valid", dev_tx_valid, 2'b10);
    check("R8 data write ignored while busy", dev_tx_data[15:8], 8'h5A);
    repeat (3) @(posedge clk);
    #2 check("R4 tx held", {dev_tx_valid, dev_tx_data[15:8]}, {2'b10, 8'h5A});
    bus_read(ra(1, 1), v);
    check("R4 busy during send", v, 8'h01);
    @(negedge clk); dev_tx_ready[1] = 1;
    @(posedge clk); #2; dev_tx_ready[1] = 0;
    check("R4 tx done", dev_tx_valid, 2'b00);
    bus_read(ra(1, 1), v);
    check("R4 idle, no ready", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bus_write(ra(0, 2), 8'h10);
    bus_read(ra(0, 1), v);
    check("R6 irq mode bit", v, 8'h10);
    bus_write(ra(0, 2), 8'h02);
    check("R9 no irq while busy", irq, 1'b0);
    dev_give(0, 8'h0F, 0);
    check("R9 irq on data", irq, 1'b1);
    bus_read(ra(0, 0), v);
    check("R10 data in irq mode", v, 8'h0F);
    check("R10 irq dropped", irq, 1'b0);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_fetch_poll();
    t_parity();
    t_start();
    t_test_cmd();
    t_decode();
    t_busy_and_send();
    t_irq();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule